// File: doc/BRIEF.md
# Multiplexed Host Register Bus Slave

This block lets an external host reach a small internal register file over a narrow parallel bus. The bus is one byte wide and bidirectional. Active-low chip select, write strobe and read strobe control it, and a separate select line tells whether a cycle carries an index or register data. Each register access takes two bus cycles. First, an address cycle stores a register index. Then one or more data cycles read or write the register at that stored index. An active-low ready output tells the host when a cycle has been taken. An active-low interrupt output passes an internal request out to the host.

Inside the chip, the block presents the stored index, the write byte and a one-clock write-enable pulse to the downstream registers. It takes back a read byte for the current index. The block decodes the index itself. Unmapped indices read as zero and produce no write pulse. One index holds a read-only revision constant.

The control inputs are asynchronous to the block clock. Each one passes through a synchroniser, and the block acts on the falling edge of a strobe while chip select is low.

Top module: `hb_host_slave`

## Requirements
- R1: After reset, `host_rdy_n` and `host_irq_n` are 1, `reg_wen` is 0 and `reg_idx` is 0x00.
- R2: A write strobe with `host_sel_addr` = 1 stores the data byte as the register index and raises no `reg_wen`.
- R3: A write strobe with `host_sel_addr` = 0 to a writable index gives exactly one `reg_wen` pulse of one clock, with `reg_idx` and `reg_wdata` equal to the index and the byte.
- R4: Mapped indices are bit positions of a 16-bit map with bits 0, 1, 4 to 10, 12, 13 and 15 set. Any other index, including every index of 16 or more, ignores writes (no `reg_wen`) and reads back 0x00.
- R5: Index 15 is read-only. It reads back the `REVISION` parameter, and a write to it raises no `reg_wen`.
- R6: A read strobe with `host_sel_addr` = 0 at a writable index returns `reg_rdata` for that index on the data bus.
- R7: A read strobe with `host_sel_addr` = 1 returns the stored register index.
- R8: With chip select low, `host_rdy_n` goes low on the third rising clock edge after a strobe falls. It stays low until the third rising edge after the strobe rises.
- R9: The block drives `host_data` only while both `host_cs_n` and `host_rd_n` are low. Otherwise it leaves the bus undriven.
- R10: Strobes while `host_cs_n` is high have no effect: no ready, no index change and no `reg_wen`.
- R11: `host_irq_n` equals the inverse of `irq_req`, one clock later.
- R12: The stored index persists across data cycles, so successive data cycles reach the same register without a new address cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Active-low chip select from host |
| host_sel_addr | input | 1 | 1: index cycle, 0: register data cycle |
| host_wr_n | input | 1 | Active-low write strobe |
| host_rd_n | input | 1 | Active-low read strobe |
| host_data | inout | 8 | Bidirectional data byte |
| host_rdy_n | output | 1 | Active-low cycle-taken indication |
| host_irq_n | output | 1 | Active-low interrupt to host |
| irq_req | input | 1 | Active-high interrupt request from inside |
| reg_idx | output | 8 | Stored register index |
| reg_wdata | output | 8 | Write byte for downstream registers |
| reg_wen | output | 1 | One-clock write-enable pulse |
| reg_rdata | input | 8 | Read byte from downstream for `reg_idx` |

## Verification
The bench builds the block with the default 16-entry index map and revision index 15, two synchroniser stages, and `REVISION` overridden to 0xA7. This makes the revision read distinguishable from downstream data and from zero. With two sync stages, the ready latency is exactly three edges, so the bench can pin the ready timing cycle by cycle. The 16-entry map puts unmapped holes at 2, 3, 11 and 14, as well as indices at and above 16, within reach of short address cycles. The downstream model seeds every register with a nonzero value, so masking to zero is visible.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int HB_BYTE_W = 8;

    typedef struct packed {
        logic [HB_BYTE_W-1:0] idx;
        logic [HB_BYTE_W-1:0] wdata;
        logic [HB_BYTE_W-1:0] rdata;
        logic                 wen;
        logic                 rdy_n;
        logic                 irq_n;
    } hb_state_t;

    localparam hb_state_t HB_STATE_RST = '{
        idx:   '0,
        wdata: '0,
        rdata: '0,
        wen:   1'b0,
        rdy_n: 1'b1,
        irq_n: 1'b1
    };
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] d;
            if (s == 0) begin : g_first
                assign d = async_i;
            end else begin : g_next
                assign d = chain_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= d;
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hb_edge.sv
module hb_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/hb_decode.sv
module hb_decode #(
    parameter int                 BYTE_W   = 8,
    parameter int                 NUM_IDX  = 16,
    parameter logic [NUM_IDX-1:0] USED_MAP = 16'hB7F3,
    parameter int                 REV_IDX  = 15
) (
    input  logic [BYTE_W-1:0] idx_i,
    output logic              mapped_o,
    output logic              writable_o,
    output logic              is_rev_o
);
    logic [NUM_IDX-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < NUM_IDX; i++) begin : g_hit
            if (USED_MAP[i]) begin : g_used
                assign hit[i] = (idx_i == BYTE_W'(i));
            end else begin : g_hole
                assign hit[i] = 1'b0;
            end
        end
    endgenerate

    assign mapped_o   = |hit;
    assign is_rev_o   = (idx_i == BYTE_W'(REV_IDX));
    assign writable_o = mapped_o & ~is_rev_o;
endmodule

// File: rtl/hb_host_slave.sv
module hb_host_slave #(
    parameter int                 NUM_IDX     = 16,
    parameter logic [NUM_IDX-1:0] USED_MAP    = 16'hB7F3,
    parameter int                 REV_IDX     = 15,
    parameter logic [7:0]         REVISION    = 8'h2C,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_cs_n,
    input  logic       host_sel_addr,
    input  logic       host_wr_n,
    input  logic       host_rd_n,
    inout  wire  [7:0] host_data,
    output logic       host_rdy_n,
    output logic       host_irq_n,
    input  logic       irq_req,
    output logic [7:0] reg_idx,
    output logic [7:0] reg_wdata,
    output logic       reg_wen,
    input  logic [7:0] reg_rdata
);
    import hb_pkg::*;

    localparam int CTL_W = 3;
    localparam int B_CS  = 0;
    localparam int B_WR  = 1;
    localparam int B_RD  = 2;

    logic [CTL_W-1:0] ctl_raw, ctl_lvl, ctl_fall;
    logic             act_wr, act_rd, strobes_idle;
    logic             idx_mapped, idx_writable, idx_is_rev;
    logic [HB_BYTE_W-1:0] bus_in;
    hb_state_t        st_d, st_q;

    assign ctl_raw = {host_rd_n, host_wr_n, host_cs_n};
    assign bus_in  = host_data;

    hb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_raw),
        .sync_o  (ctl_lvl)
    );

    hb_edge #(.W(CTL_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (ctl_lvl),
        .fall_o (ctl_fall)
    );

    hb_decode #(
        .BYTE_W   (HB_BYTE_W),
        .NUM_IDX  (NUM_IDX),
        .USED_MAP (USED_MAP),
        .REV_IDX  (REV_IDX)
    ) u_dec (
        .idx_i      (st_q.idx),
        .mapped_o   (idx_mapped),
        .writable_o (idx_writable),
        .is_rev_o   (idx_is_rev)
    );

    // Write wins if both strobes fall together.
    assign act_wr       = ctl_fall[B_WR] & ~ctl_lvl[B_CS];
    assign act_rd       = ctl_fall[B_RD] & ~ctl_lvl[B_CS] & ~act_wr;
    assign strobes_idle = ctl_lvl[B_WR] & ctl_lvl[B_RD];

    always_comb begin
        st_d       = st_q;
        st_d.wen   = 1'b0;
        st_d.irq_n = ~irq_req;
        if (act_wr) begin
            st_d.rdy_n = 1'b0;
            if (host_sel_addr) begin
                st_d.idx = bus_in;
            end else if (idx_writable) begin
                st_d.wen   = 1'b1;
                st_d.wdata = bus_in;
            end
        end else if (act_rd) begin
            st_d.rdy_n = 1'b0;
            if (host_sel_addr)     st_d.rdata = st_q.idx;
            else if (idx_is_rev)   st_d.rdata = REVISION;
            else if (idx_mapped)   st_d.rdata = reg_rdata;
            else                   st_d.rdata = '0;
        end else if (strobes_idle) begin
            st_d.rdy_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HB_STATE_RST;
        else        st_q <= st_d;
    end

    assign host_data  = (!host_cs_n && !host_rd_n) ? st_q.rdata : 8'bz;
    assign host_rdy_n = st_q.rdy_n;
    assign host_irq_n = st_q.irq_n;
    assign reg_idx    = st_q.idx;
    assign reg_wdata  = st_q.wdata;
    assign reg_wen    = st_q.wen;
endmodule

// File: rtl/hb_host_slave_chk.sv
module hb_host_slave_chk #(
    parameter int                 NUM_IDX  = 16,
    parameter logic [NUM_IDX-1:0] USED_MAP = 16'hB7F3,
    parameter int                 REV_IDX  = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_req,
    input logic       host_irq_n,
    input logic       host_rdy_n,
    input logic [7:0] reg_idx,
    input logic       reg_wen
);
    function automatic logic idx_writable(input logic [7:0] i);
        logic ok;
        ok = 1'b0;
        for (int k = 0; k < NUM_IDX; k++)
            if (USED_MAP[k] && i == 8'(k) && k != REV_IDX) ok = 1'b1;
        return ok;
    endfunction

    // R3: write-enable is a single-clock pulse
    p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen |=> !reg_wen);

    // R4 and R5: pulses only for mapped, non read-only indices
    p_wr_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen |-> idx_writable(reg_idx));

    // R8: ready is low whenever a write is being handed downstream
    p_rdy_with_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen |-> !host_rdy_n);

    // R12: index only moves when a cycle is taken
    p_idx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(host_rdy_n) |-> $stable(reg_idx));

    // R11: interrupt output follows request, inverted, one clock later
    p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (host_irq_n == !$past(irq_req)));
endmodule

bind hb_host_slave hb_host_slave_chk #(
    .NUM_IDX  (NUM_IDX),
    .USED_MAP (USED_MAP),
    .REV_IDX  (REV_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .host_irq_n (host_irq_n),
    .host_rdy_n (host_rdy_n),
    .reg_idx    (reg_idx),
    .reg_wen    (reg_wen)
);

// File: tb/hb_host_slave_bench.sv
module hb_host_slave_bench;
    localparam logic [7:0] REV = 8'hA7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sel_a = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_val = 8'h00;
    wire  [7:0] bus;
    logic       rdy_n, irq_n, irq_req = 1'b0, wen;
    logic [7:0] idx, wdata, rdata;
    logic [7:0] dn_mem [16];

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic [7:0] cur_idx = 8'h00;

    typedef struct { logic [7:0] idx; logic [7:0] data; } wr_item_t;
    wr_item_t exp_q[$];

    always #10 clk = ~clk;

    assign bus = tb_drv ? tb_val : 8'bz;
    assign rdata = (idx < 8'd16) ? dn_mem[idx[3:0]] : 8'hEE;

    hb_host_slave #(.REVISION(REV)) u_hb_host_slave (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_sel_addr(sel_a),
        .host_wr_n(wr_n), .host_rd_n(rd_n), .host_data(bus),
        .host_rdy_n(rdy_n), .host_irq_n(irq_n), .irq_req(irq_req),
        .reg_idx(idx), .reg_wdata(wdata), .reg_wen(wen), .reg_rdata(rdata)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic logic writable(input logic [7:0] i);
        return i inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8,
                         8'd9, 8'd10, 8'd12, 8'd13};
    endfunction

    // Monitor: pops expected writes as the design emits pulses (R3, R4, R5)
    always @(negedge clk) begin
        if (rst_n && wen) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4: unexpected write pulse idx 0x%02h data 0x%02h (expected none)", idx, wdata);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                if (idx !== it.idx || wdata !== it.data) begin
                    fails++;
                    $display("FAIL R3: actual idx 0x%02h data 0x%02h expected idx 0x%02h data 0x%02h",
                             idx, wdata, it.idx, it.data);
                end
            end
            if (idx < 8'd16) dn_mem[idx[3:0]] = wdata;
        end
    end

    task automatic bus_op(input logic sel, input logic is_wr, input logic [7:0] val,
                          output logic [7:0] got);
        int n;
        @(negedge clk);
        cs_n = 1'b0; sel_a = sel;
        if (is_wr) begin tb_drv = 1'b1; tb_val = val; end
        @(negedge clk);
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        n = 0;
        while (rdy_n !== 1'b0 && n < 40) begin @(negedge clk); n++; end
        if (n >= 40) chk("R8", {7'd0, rdy_n}, 8'h00);
        got = bus;
        wr_n = 1'b1; rd_n = 1'b1;
        n = 0;
        while (rdy_n !== 1'b1 && n < 40) begin @(negedge clk); n++; end
        if (n >= 40) chk("R8", {7'd0, rdy_n}, 8'h01);
        cs_n = 1'b1; tb_drv = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_idx(input logic [7:0] i);
        logic [7:0] g;
        bus_op(1'b1, 1'b1, i, g);
        cur_idx = i;
    endtask

    task automatic wr_reg(input logic [7:0] v);
        logic [7:0] g;
        if (writable(cur_idx)) exp_q.push_back('{idx: cur_idx, data: v});
        bus_op(1'b0, 1'b1, v, g);
    endtask

    task automatic rd_reg(output logic [7:0] g);
        bus_op(1'b0, 1'b0, 8'h00, g);
    endtask

    initial begin
        logic [7:0] got;
        for (int i = 0; i < 16; i++) dn_mem[i] = 8'h80 | 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdy_n", {7'd0, rdy_n}, 8'h01);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 wen",   {7'd0, wen},   8'h00);
        chk("R1 idx",   idx,           8'h00);

        // R2: address cycle stores index, no pulse
        set_idx(8'h05);
        chk("R2 idx", idx, 8'h05);
        chk("R2 no pulse queued", 8'(exp_q.size()), 8'h00);

        // R3, R6: write then read back
        wr_reg(8'h5A);
        rd_reg(got);
        chk("R6 read idx5", got, 8'h5A);

        // R12: second data cycle without new address
        wr_reg(8'h3C);
        rd_reg(got);
        chk("R12 reuse idx", got, 8'h3C);
        chk("R12 idx kept", idx, 8'h05);

        // R3, R6 across several writable indices
        foreach (dn_mem[k]) begin
            logic [7:0] ii;
            ii = 8'(k);
            if (writable(ii)) begin
                set_idx(ii);
                wr_reg(8'h11 + ii * 8'd7);
                rd_reg(got);
                chk("R6 sweep", got, 8'h11 + ii * 8'd7);
            end
        end

        // R4: unmapped holes and out-of-range indices
        set_idx(8'h02);
        wr_reg(8'h77);
        rd_reg(got);
        chk("R4 hole 0x02 reads zero", got, 8'h00);
        set_idx(8'h0E);
        rd_reg(got);
        chk("R4 hole 0x0E reads zero", got, 8'h00);
        set_idx(8'h20);
        wr_reg(8'h99);
        rd_reg(got);
        chk("R4 idx 0x20 reads zero", got, 8'h00);

        // R5: revision index
        set_idx(8'h0F);
        rd_reg(got);
        chk("R5 revision", got, REV);
        wr_reg(8'h00);
        rd_reg(got);
        chk("R5 revision after write", got, REV);

        // R7: index read-back
        set_idx(8'h0C);
        bus_op(1'b1, 1'b0, 8'h00, got);
        chk("R7 index read", got, 8'h0C);

        // R8: exact ready timing
        @(negedge clk);
        cs_n = 1'b0; sel_a = 1'b1; tb_drv = 1'b1; tb_val = 8'h09;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 rdy before 3rd edge", {7'd0, rdy_n}, 8'h01);
        @(posedge clk); @(negedge clk);
        chk("R8 rdy at 3rd edge", {7'd0, rdy_n}, 8'h00);
        wr_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 rdy held", {7'd0, rdy_n}, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R8 rdy released", {7'd0, rdy_n}, 8'h01);
        cs_n = 1'b1; tb_drv = 1'b0;
        cur_idx = 8'h09;
        repeat (2) @(negedge clk);

        // R9: bus not driven while chip select high (last read left 0x0C latched)
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; tb_drv = 1'b1; tb_val = 8'h00;
        @(negedge clk);
        chk("R9 bus released", bus, 8'h00);
        rd_n = 1'b1; tb_drv = 1'b0;
        repeat (4) @(negedge clk);

        // R10: strobes ignored while chip select high
        sel_a = 1'b1; tb_drv = 1'b1; tb_val = 8'h0D;
        wr_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 no ready", {7'd0, rdy_n}, 8'h01);
        chk("R10 idx unchanged", idx, 8'h09);
        wr_n = 1'b1; tb_drv = 1'b0;
        sel_a = 1'b0; tb_drv = 1'b1; tb_val = 8'h44;
        wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1; tb_drv = 1'b0;
        repeat (4) @(negedge clk);
        rd_reg(got);
        chk("R10 data unchanged", got, 8'h11 + 8'd9 * 8'd7);

        // R11: interrupt output
        irq_req = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R11 irq asserted", {7'd0, irq_n}, 8'h00);
        irq_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R11 irq released", {7'd0, irq_n}, 8'h01);

        repeat (4) @(negedge clk);
        chk("R3 all expected writes seen", 8'(exp_q.size()), 8'h00);
        summary();
        $finish;
    end
endmodule